// File: doc/BRIEF.md
# Register-Mapped Signed Integer Divider

This block is a division peripheral that sits on a 32-bit register bus. Software loads a 64-bit dividend and a 64-bit divisor, one 32-bit word at a time, and picks an operand-width mode in a control word. Every write to one of the four operand words or to the control word starts a new signed division on the current register contents. While the division runs, a busy bit in the control word is set. The busy time is fixed by the mode. When busy clears, the quotient and remainder words hold the result.

The divider works on magnitudes. It produces one quotient bit per cycle with restoring shift-and-subtract, and applies the signs at the end. In the narrow mode the iteration count is halved. The control flow is a four-state machine:

- `S_IDLE`: nothing to do. A start moves it to `S_LOAD`.
- `S_LOAD`: sign-extends the operands for the mode, takes their magnitudes and loads the latency counter. It always moves to `S_ITER`.
- `S_ITER`: produces one quotient bit per cycle. When the last bit is done it moves to `S_HOLD`.
- `S_HOLD`: waits for the latency counter to run out. When it does, the signed result is published and the state returns to `S_IDLE`.

A start seen in any state sends the machine back to `S_LOAD`.

Top module: `sdiv_mmio`

## Requirements
- R1: After reset every readable word reads zero: mode 0, both flags clear, zero operands and zero results. Unmapped addresses always read zero.
- R2: The dividend low and high words are at byte offsets 0x290 and 0x294. The divisor low and high words are at 0x298 and 0x29C. Each word reads back the last value written to it.
- R3: Mode code 0 divides the sign-extended low word of the dividend by the sign-extended low word of the divisor. The high words have no effect.
- R4: Mode codes 1 and 3 behave identically. Each divides the full 64-bit dividend by the sign-extended low word of the divisor.
- R5: Mode code 2 divides the full 64-bit dividend by the full 64-bit divisor.
- R6: The control word is at offset 0x280 and busy is its bit 15. Busy reads 1 from the cycle after a start for 36 cycles in mode 0, or for 68 cycles in every other mode. The results update in the cycle busy clears.
- R7: A start is any write to 0x280, 0x290, 0x294, 0x298 or 0x29C. A start during busy abandons the running division and restarts the full busy period using the new contents.
- R8: The quotient is truncated toward zero and the remainder takes the sign of the dividend. The most negative dividend of the mode divided by -1 gives the positive magnitude as a 64-bit quotient (0x8000_0000_0000_0000 in 64-bit modes) and remainder 0.
- R9: When the divisor is zero over the width the mode uses, the divide-by-zero flag (control bit 14) is set when the result is published. The quotient is then -1 for a non-negative dividend and +1 for a negative one, and the remainder equals the sign-extended dividend. A non-zero divisor clears the flag.
- R10: The quotient words at 0x2A0/0x2A4 and the remainder words at 0x2A8/0x2AC are read-only. Writes to them change nothing and start nothing. Control bits other than [1:0] ignore writes.
- R11: Control bits [1:0] hold the mode code and read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Word write strobe, one cycle per write |
| bus_addr | input | 12 | Byte offset of the accessed word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |

## Verification
The assertions assume that each write is a single-cycle strobe with a whole 32-bit word. They also assume that reset is held long enough to clear the state machine, after which nothing but bus writes can start work. The stimulus writes only through a task that raises `bus_we` for exactly one cycle and then parks the address on the control word. Reads are rotated over the mapped words and one unmapped word. It covers each mode code, zero divisors whose upper divisor bits are set, minimum-negative over -1, restarts in mid-division, and writes to read-only words while busy. A behavioural model built on the bench's own 64-bit arithmetic predicts the read data, and the read data is compared with it on every clock.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;
    localparam int unsigned BUS_W = 32;
    localparam int unsigned OPW   = 2 * BUS_W;

    localparam logic [11:0] A_CTRL   = 12'h280;
    localparam logic [11:0] A_NUM_LO = 12'h290;
    localparam logic [11:0] A_QUO_LO = 12'h2A0;
    localparam logic [11:0] A_QUO_HI = 12'h2A4;
    localparam logic [11:0] A_REM_LO = 12'h2A8;
    localparam logic [11:0] A_REM_HI = 12'h2AC;

    localparam int unsigned CTRL_DZ_BIT   = 14;
    localparam int unsigned CTRL_BUSY_BIT = 15;

    // mode code 3 is an alias of code 1
    typedef enum logic [1:0] {
        MD_N32_D32 = 2'd0,
        MD_N64_D32 = 2'd1,
        MD_N64_D64 = 2'd2,
        MD_N64_D32_ALT = 2'd3
    } div_mode_e;
endpackage

// File: rtl/sdiv_regs.sv
module sdiv_regs
    import sdiv_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_we,
    input  logic [11:0]      bus_addr,
    input  logic [BUS_W-1:0] bus_wdata,
    output logic [OPW-1:0]   num,
    output logic [OPW-1:0]   den,
    output logic [1:0]       mode,
    output logic             start
);
    localparam int unsigned NWORDS = 2 * OPW / BUS_W;

    logic [NWORDS-1:0]            hit;
    logic [NWORDS-1:0][BUS_W-1:0] words;
    logic                         ctrl_hit;

    for (genvar g = 0; g < NWORDS; g++) begin : g_word
        localparam logic [11:0] WADDR = A_NUM_LO + 12'(4 * g);
        logic [BUS_W-1:0] q;
        assign hit[g] = bus_we && (bus_addr == WADDR);
        always_ff @(posedge clk) begin
            if (!rst_n)      q <= '0;
            else if (hit[g]) q <= bus_wdata;
        end
        assign words[g] = q;
    end

    assign ctrl_hit = bus_we && (bus_addr == A_CTRL);

    always_ff @(posedge clk) begin
        if (!rst_n)        mode <= MD_N32_D32;
        else if (ctrl_hit) mode <= bus_wdata[1:0];
    end

    assign num   = {words[1], words[0]};
    assign den   = {words[3], words[2]};
    assign start = ctrl_hit || (|hit);

    AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr != A_CTRL) |=> $stable(mode)); // R10
    AST_START_ON_OPERAND: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_NUM_LO) |-> start); // R7
endmodule

// File: rtl/sdiv_core.sv
module sdiv_core
    import sdiv_pkg::*;
#(
    parameter int unsigned LAT_SHORT = 36,
    parameter int unsigned LAT_LONG  = 68
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [1:0]     mode,
    input  logic [OPW-1:0] num,
    input  logic [OPW-1:0] den,
    output logic           busy,
    output logic [OPW-1:0] quot,
    output logic [OPW-1:0] rem,
    output logic           dz
);
    localparam int unsigned HALF  = OPW / 2;
    localparam int unsigned CNT_W = $clog2(LAT_LONG + 1);
    localparam int unsigned IT_W  = $clog2(OPW + 1);

    typedef enum logic [1:0] {S_IDLE, S_LOAD, S_ITER, S_HOLD} st_e;

    st_e              st, st_nx;
    logic [CNT_W-1:0] cnt;
    logic [IT_W-1:0]  itr;
    logic [OPW:0]     rr, trial;
    logic [OPW-1:0]   qq, dd, num_keep;
    logic [OPW-1:0]   en, ed, an, ad;
    logic             neg_q, neg_r, zero_d, fit, short_m, narrow_d, last_cnt;

    always_comb begin
        short_m  = (mode == MD_N32_D32);
        narrow_d = (mode != MD_N64_D64);
        en = short_m  ? {{HALF{num[HALF-1]}}, num[HALF-1:0]} : num;
        ed = narrow_d ? {{HALF{den[HALF-1]}}, den[HALF-1:0]} : den;
        an = en[OPW-1] ? -en : en;
        ad = ed[OPW-1] ? -ed : ed;
        trial    = {rr[OPW-1:0], qq[OPW-1]};
        fit      = (trial >= {1'b0, dd});
        last_cnt = (cnt == CNT_W'(1));
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            S_IDLE: st_nx = S_IDLE;
            S_LOAD: st_nx = S_ITER;
            S_ITER: if (itr == IT_W'(1)) st_nx = S_HOLD;
            S_HOLD: if (last_cnt) st_nx = S_IDLE;
        endcase
        if (start) st_nx = S_LOAD;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= S_IDLE;
            cnt <= '0;
        end else begin
            st <= st_nx;
            if (start)             cnt <= '0;
            else if (st == S_LOAD) cnt <= short_m ? CNT_W'(LAT_SHORT - 1) : CNT_W'(LAT_LONG - 1);
            else if (cnt != '0)    cnt <= cnt - CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            itr <= '0; rr <= '0; qq <= '0; dd <= '0; num_keep <= '0;
            neg_q <= 1'b0; neg_r <= 1'b0; zero_d <= 1'b0;
            quot <= '0; rem <= '0; dz <= 1'b0;
        end else begin
            unique case (st)
                S_IDLE: ;
                S_LOAD: begin
                    itr      <= short_m ? IT_W'(HALF) : IT_W'(OPW);
                    qq       <= short_m ? {an[HALF-1:0], {HALF{1'b0}}} : an;
                    rr       <= '0;
                    dd       <= ad;
                    neg_q    <= en[OPW-1] ^ ed[OPW-1];
                    neg_r    <= en[OPW-1];
                    zero_d   <= (ed == '0);
                    num_keep <= en;
                end
                S_ITER: begin
                    itr <= itr - IT_W'(1);
                    qq  <= {qq[OPW-2:0], fit};
                    rr  <= fit ? trial - {1'b0, dd} : trial;
                end
                S_HOLD: if (last_cnt && !start) begin
                    if (zero_d) begin
                        quot <= num_keep[OPW-1] ? OPW'(1) : '1;
                        rem  <= num_keep;
                        dz   <= 1'b1;
                    end else begin
                        quot <= neg_q ? -qq : qq;
                        rem  <= neg_r ? -rr[OPW-1:0] : rr[OPW-1:0];
                        dz   <= 1'b0;
                    end
                end
            endcase
        end
    end

    assign busy = (st != S_IDLE);

    AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy); // R6
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < CNT_W'(LAT_LONG)); // R6
    AST_BITS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_ITER) |-> (cnt > CNT_W'(1))); // R6
    AST_DZ_QUOT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dz) |-> (quot == OPW'(1) || quot == '1)); // R9
    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && $past(!busy)) |-> ($stable(quot) && $stable(rem))); // R10
endmodule

// File: rtl/sdiv_mmio.sv
module sdiv_mmio
    import sdiv_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_we,
    input  logic [11:0] bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata
);
    logic [OPW-1:0] num, den, quot, rem;
    logic [1:0]     mode;
    logic           start, busy, dz;

    sdiv_regs u_regs (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .num(num), .den(den), .mode(mode), .start(start)
    );

    sdiv_core #(.LAT_SHORT(36), .LAT_LONG(68)) u_core (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .num(num),
        .den(den), .busy(busy), .quot(quot), .rem(rem), .dz(dz)
    );

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_CTRL: begin
                bus_rdata[1:0]           = mode;
                bus_rdata[CTRL_DZ_BIT]   = dz;
                bus_rdata[CTRL_BUSY_BIT] = busy;
            end
            A_NUM_LO:         bus_rdata = num[BUS_W-1:0];
            A_NUM_LO + 12'h4: bus_rdata = num[OPW-1:BUS_W];
            A_NUM_LO + 12'h8: bus_rdata = den[BUS_W-1:0];
            A_NUM_LO + 12'hC: bus_rdata = den[OPW-1:BUS_W];
            A_QUO_LO:         bus_rdata = quot[BUS_W-1:0];
            A_QUO_HI:         bus_rdata = quot[OPW-1:BUS_W];
            A_REM_LO:         bus_rdata = rem[BUS_W-1:0];
            A_REM_HI:         bus_rdata = rem[OPW-1:BUS_W];
            default:          bus_rdata = '0;
        endcase
    end
endmodule

// File: tb/sdiv_mmio_tb.sv
`timescale 1ns/1ps
module sdiv_mmio_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [11:0] bus_addr = 12'h280;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;

    int    n_chk = 0;
    int    n_bad = 0;
    bit    chk_on = 1'b0;
    bit    done = 1'b0;
    string cur_req = "R1";

    always #2.5 clk = ~clk;

    sdiv_mmio dut_i (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    // behavioural model
    logic [63:0] m_num, m_den, m_q, m_r, p_q, p_r;
    logic [1:0]  m_mode;
    logic        m_dz, p_dz, m_go;
    int          m_cnt;

    function automatic void ref_div(input logic [1:0] m, input logic [63:0] n, input logic [63:0] d,
                                    output logic [63:0] q, output logic [63:0] r, output logic z);
        logic [63:0] a, b, ma, mb;
        a  = (m == 2'd0) ? {{32{n[31]}}, n[31:0]} : n;
        b  = (m == 2'd2) ? d : {{32{d[31]}}, d[31:0]};
        ma = a[63] ? (~a + 64'd1) : a;
        mb = b[63] ? (~b + 64'd1) : b;
        if (b == 64'd0) begin
            z = 1'b1; r = a;
            q = a[63] ? 64'd1 : {64{1'b1}};
        end else begin
            z = 1'b0;
            q = ma / mb;
            r = ma % mb;
            if (a[63] ^ b[63]) q = ~q + 64'd1;
            if (a[63])         r = ~r + 64'd1;
        end
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_num = '0; m_den = '0; m_mode = '0; m_q = '0; m_r = '0; m_dz = 0; m_cnt = 0;
        end else begin
            m_go = 1'b0;
            if (bus_we) begin
                case (bus_addr)
                    12'h280: begin m_mode = bus_wdata[1:0]; m_go = 1; end
                    12'h290: begin m_num[31:0]  = bus_wdata; m_go = 1; end
                    12'h294: begin m_num[63:32] = bus_wdata; m_go = 1; end
                    12'h298: begin m_den[31:0]  = bus_wdata; m_go = 1; end
                    12'h29C: begin m_den[63:32] = bus_wdata; m_go = 1; end
                    default: ;
                endcase
            end
            if (m_go) begin
                ref_div(m_mode, m_num, m_den, p_q, p_r, p_dz);
                m_cnt = (m_mode == 2'd0) ? 36 : 68;
            end else if (m_cnt > 0) begin
                m_cnt = m_cnt - 1;
                if (m_cnt == 0) begin m_q = p_q; m_r = p_r; m_dz = p_dz; end
            end
        end
    end

    function automatic logic [31:0] model_read(input logic [11:0] a);
        case (a)
            12'h280: return {16'd0, (m_cnt != 0), m_dz, 12'd0, m_mode};
            12'h290: return m_num[31:0];
            12'h294: return m_num[63:32];
            12'h298: return m_den[31:0];
            12'h29C: return m_den[63:32];
            12'h2A0: return m_q[31:0];
            12'h2A4: return m_q[63:32];
            12'h2A8: return m_r[31:0];
            12'h2AC: return m_r[63:32];
            default: return 32'd0;
        endcase
    endfunction

    always @(posedge clk) begin
        #1;
        if (chk_on && !done) begin
            logic [31:0] exp_v;
            exp_v = model_read(bus_addr);
            n_chk++;
            if (bus_rdata !== exp_v) begin
                n_bad++;
                $display("FAIL %s addr=%h actual=%h expected=%h", cur_req, bus_addr, bus_rdata, exp_v);
            end
        end
    end

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0; bus_addr = 12'h280;
    endtask

    task automatic watch(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            case (i % 6)
                0: bus_addr = 12'h280;
                1: bus_addr = 12'h2A0;
                2: bus_addr = 12'h2A4;
                3: bus_addr = 12'h2A8;
                4: bus_addr = 12'h2AC;
                default: bus_addr = 12'h2B4;
            endcase
        end
    endtask

    task automatic run(input string tag, input logic [1:0] m, input logic [63:0] n, input logic [63:0] d);
        cur_req = tag;
        wr(12'h290, n[31:0]);
        wr(12'h294, n[63:32]);
        wr(12'h298, d[31:0]);
        wr(12'h29C, d[63:32]);
        wr(12'h280, {30'd0, m});
        watch(74);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        chk_on = 1'b1;
        cur_req = "R1";
        watch(12);
        cur_req = "R2";
        wr(12'h290, 32'hDEAD_0001); wr(12'h294, 32'h1234_5678);
        wr(12'h298, 32'hCAFE_0002); wr(12'h29C, 32'h0BAD_F00D);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk); bus_addr = 12'h290 + 12'(4 * k);
        end
        watch(74);
        run("R3", 2'd0, {32'hFFFF_0000, 32'd100}, {32'h7777_7777, 32'd7});
        run("R3", 2'd0, {32'h0, -32'sd100}, {32'h0, 32'd7});
        run("R8", 2'd0, 64'd100, {32'h0, -32'sd7});
        run("R8", 2'd0, {32'h1, 32'h8000_0000}, {32'h0, 32'hFFFF_FFFF});
        run("R4", 2'd1, 64'h0123_4567_89AB_CDEF, {32'h5555_0000, 32'd1000});
        run("R4", 2'd3, 64'h0123_4567_89AB_CDEF, {32'h5555_0000, 32'd1000});
        run("R4", 2'd3, -64'sd1_000_000_007, {32'h0, -32'sd13});
        run("R5", 2'd2, 64'h7FFF_FFFF_FFFF_FFFF, 64'h0000_0003_0000_0001);
        run("R5", 2'd2, -64'sd98765432109, 64'sd12345);
        run("R8", 2'd2, 64'h8000_0000_0000_0000, {64{1'b1}});
        run("R8", 2'd1, 64'h8000_0000_0000_0000, {32'h0, 32'hFFFF_FFFF});
        run("R9", 2'd0, 64'd55, 64'h0000_0001_0000_0000);
        run("R9", 2'd0, {32'h0, -32'sd55}, 64'h0);
        run("R9", 2'd2, -64'sd9, 64'h0);
        run("R9", 2'd2, 64'd55, 64'h0000_0001_0000_0000);
        // restart while busy
        cur_req = "R7";
        wr(12'h290, 32'd1000); wr(12'h298, 32'd3); wr(12'h280, 32'd0);
        watch(20);
        wr(12'h290, 32'd999);
        watch(10);
        wr(12'h280, 32'd2);
        watch(74);
        // read-only words and control high bits
        cur_req = "R10";
        wr(12'h2A0, 32'h1111_1111);
        wr(12'h2AC, 32'h2222_2222);
        watch(12);
        wr(12'h280, 32'hFFFF_FFFC);
        watch(20);
        wr(12'h2A8, 32'h3333_3333);
        watch(74);
        cur_req = "R11";
        wr(12'h280, 32'd1); watch(4);
        wr(12'h280, 32'd3); watch(74);
        cur_req = "R6";
        wr(12'h280, 32'd0); watch(40);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog %s actual=running expected=finished", cur_req);
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule